// File: doc/BRIEF.md
# Event Performance Monitor Counters

This block is a small bank of four 32-bit up-counters for profiling a processor. Each counter watches one line of a 16-line event bus, picked by its own control register, and adds one on every clock edge where that line is high and nothing freezes it. A counter can be frozen unconditionally. It can also be frozen only while the core runs in supervisor state, only while it runs in user state, or depending on the level of the core's mark input.

Software loads a counter with 0x80000000 minus N. The counter's top bit then becomes set after N counted events, and this bit is the counter's condition. When a counter's condition-enable bit is set, its condition drives the interrupt output through a global interrupt enable. It can also freeze the whole bank in hardware, so that the counts stay still while software handles the interrupt. All registers are reached through a single-cycle write port and a combinational read port.

Top module: `event_counter_bank`

## Requirements
- R1: After reset, every count register reads 0, every local control register reads 0x00003E00 (all five freeze bits set, select 0, condition enable 0), the global register reads 0x00000001 (freeze-all set) and `irq` is low.
- R2: Address bits [3:2] select the group: 0 is the global register, 1 is a count register and 2 is a local control register, with bits [1:0] giving the counter index. Group 3 reads zero. The local control layout is select [3:0], condition enable bit 8, freeze-always bit 9, freeze-in-supervisor bit 10, freeze-in-user bit 11, freeze-when-mark-low bit 12 and freeze-when-mark-high bit 13. The global layout is freeze-all bit 0, interrupt enable bit 1 and freeze-on-condition bit 2. Unused bits read zero.
- R3: An unfrozen counter adds exactly one at each clock edge where the event line named by its select field is high, ignores all other event lines, and the new value is readable in the cycle after that edge.
- R4: Freeze-always (bit 9) stops the counter whatever the other inputs are.
- R5: Bit 10 stops the counter while `supervisor` is 1, and bit 11 stops it while `supervisor` is 0.
- R6: Bit 12 stops the counter while `mark` is 0, and bit 13 stops it while `mark` is 1.
- R7: Global freeze-all stops every counter regardless of its local settings.
- R8: A write to a count register in the same cycle as a counted event loads the written value, and that increment is lost.
- R9: `irq` equals interrupt enable AND the OR over all counters of (count bit 31 AND condition enable). It is decoded from the registers with no added delay and stays high until software rewrites the counter or clears an enable.
- R10: When freeze-on-condition is set and some enabled condition is true at a clock edge, freeze-all becomes 1 at that edge. This hardware set overrides a software write that clears freeze-all in the same cycle.
- R11: A counter at 0xFFFFFFFF that counts once wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address (group in [3:2], index in [1:0]) |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| events | input | 16 | Event bus, one line per event |
| supervisor | input | 1 | 1 while the core is in supervisor state |
| mark | input | 1 | Core mark status |
| irq | output | 1 | Performance monitor interrupt request |

## Verification
A write or a counted event changes a register at the clock edge where it is sampled. Reads and `irq` come from the registers without delay, so every result is due in the cycle after that edge. Freeze-on-condition adds one more edge: the counter that reaches bit 31 still counts once more while freeze-all is being set, so a free-running counter preset to 0x7FFFFFFE stops at 0x80000001. The bench drives inputs and samples on falling edges, so each check reads exactly the state left by the rising edges it counted.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int NUM_CTR = 4;
  localparam int CNT_W   = 32;
  localparam int NUM_EVT = 16;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;
  localparam int SEL_W   = $clog2(NUM_EVT);
  localparam int IDX_W   = $clog2(NUM_CTR);

  // register groups, decoded from regAddr[3:2]
  localparam logic [1:0] GRP_GLOBAL = 2'd0;
  localparam logic [1:0] GRP_COUNT  = 2'd1;
  localparam logic [1:0] GRP_LOCAL  = 2'd2;

  // local control bit positions
  localparam int LC_CE   = 8;
  localparam int LC_FRZ  = 9;
  localparam int LC_SUP  = 10;
  localparam int LC_USR  = 11;
  localparam int LC_MK0  = 12;
  localparam int LC_MK1  = 13;

  // global control bit positions
  localparam int GC_FA   = 0;
  localparam int GC_IE   = 1;
  localparam int GC_FOC  = 2;

  typedef struct packed {
    logic [SEL_W-1:0] evtSel;
    logic             condEn;
    logic             frzAlways;
    logic             frzSup;
    logic             frzUser;
    logic             frzMark0;
    logic             frzMark1;
  } localCtl_t;

  typedef struct packed {
    logic [NUM_CTR-1:0] load;
    logic [NUM_CTR-1:0] inc;
    logic [CNT_W-1:0]   loadData;
  } ctrStrobe_t;
endpackage

// File: rtl/pmu_datapath.sv
module pmu_datapath
  import pmu_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrStrobe_t                    strobe,
  output logic [NUM_CTR-1:0][CNT_W-1:0] cntVal
);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              cntVal[i] <= '0;
      else if (strobe.load[i]) cntVal[i] <= strobe.loadData;
      else if (strobe.inc[i])  cntVal[i] <= cntVal[i] + 1'b1;
    end

    assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
      strobe.load[i] |=> cntVal[i] == $past(strobe.loadData));

    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.inc[i] && !strobe.load[i]) |=> cntVal[i] == $past(cntVal[i]) + 1'b1);

    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe.inc[i] && !strobe.load[i]) |=> $stable(cntVal[i]));

    assert_wrap_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.inc[i] && !strobe.load[i] && (&cntVal[i])) |=> cntVal[i] == '0);
  end

endmodule

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
  import pmu_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWrEn,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [DATA_W-1:0]             regWrData,
  input  logic [NUM_EVT-1:0]            events,
  input  logic                          supervisor,
  input  logic                          mark,
  input  logic [NUM_CTR-1:0][CNT_W-1:0] cntVal,
  output ctrStrobe_t                    strobe,
  output logic [DATA_W-1:0]             regRdData,
  output logic                          irq
);

  localCtl_t          lc [NUM_CTR];
  logic               gFreezeAll, gIntEn, gFoc;
  logic [1:0]         grp;
  logic [IDX_W-1:0]   idx;
  logic [NUM_CTR-1:0] condVec;
  logic               anyCond;
  logic               glbWr;

  assign grp     = regAddr[3:2];
  assign idx     = regAddr[IDX_W-1:0];
  assign glbWr   = regWrEn && (grp == GRP_GLOBAL);
  assign anyCond = |condVec;
  assign irq     = gIntEn & anyCond;

  // global control: hardware freeze is applied after the software write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gFreezeAll <= 1'b1;
      gIntEn     <= 1'b0;
      gFoc       <= 1'b0;
    end else begin
      if (glbWr) begin
        gFreezeAll <= regWrData[GC_FA];
        gIntEn     <= regWrData[GC_IE];
        gFoc       <= regWrData[GC_FOC];
      end
      if (gFoc && anyCond) gFreezeAll <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_local
    logic held;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lc[i] <= '{evtSel: '0, condEn: 1'b0, frzAlways: 1'b1, frzSup: 1'b1,
                   frzUser: 1'b1, frzMark0: 1'b1, frzMark1: 1'b1};
      end else if (regWrEn && grp == GRP_LOCAL && idx == IDX_W'(i)) begin
        lc[i].evtSel    <= regWrData[SEL_W-1:0];
        lc[i].condEn    <= regWrData[LC_CE];
        lc[i].frzAlways <= regWrData[LC_FRZ];
        lc[i].frzSup    <= regWrData[LC_SUP];
        lc[i].frzUser   <= regWrData[LC_USR];
        lc[i].frzMark0  <= regWrData[LC_MK0];
        lc[i].frzMark1  <= regWrData[LC_MK1];
      end
    end

    assign held = gFreezeAll | lc[i].frzAlways
                | (lc[i].frzSup  &  supervisor) | (lc[i].frzUser  & ~supervisor)
                | (lc[i].frzMark0 & ~mark)      | (lc[i].frzMark1 &  mark);

    assign condVec[i]     = cntVal[i][CNT_W-1] & lc[i].condEn;
    assign strobe.inc[i]  = events[lc[i].evtSel] & ~held;
    assign strobe.load[i] = regWrEn && (grp == GRP_COUNT) && (idx == IDX_W'(i));
  end

  assign strobe.loadData = regWrData[CNT_W-1:0];

  always_comb begin
    regRdData = '0;
    unique case (grp)
      GRP_GLOBAL: begin
        regRdData[GC_FA]  = gFreezeAll;
        regRdData[GC_IE]  = gIntEn;
        regRdData[GC_FOC] = gFoc;
      end
      GRP_COUNT: regRdData[CNT_W-1:0] = cntVal[idx];
      GRP_LOCAL: begin
        regRdData[SEL_W-1:0] = lc[idx].evtSel;
        regRdData[LC_CE]     = lc[idx].condEn;
        regRdData[LC_FRZ]    = lc[idx].frzAlways;
        regRdData[LC_SUP]    = lc[idx].frzSup;
        regRdData[LC_USR]    = lc[idx].frzUser;
        regRdData[LC_MK0]    = lc[idx].frzMark0;
        regRdData[LC_MK1]    = lc[idx].frzMark1;
      end
      default: regRdData = '0;
    endcase
  end

  assert_freeze_on_cond_R10: assert property (@(posedge clk) disable iff (!rstN)
    (gFoc && anyCond) |=> gFreezeAll);

  assert_frozen_no_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    (gFreezeAll && !glbWr) |=> strobe.inc == '0);

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !regWrEn && strobe.inc == '0) |=> irq);

endmodule

// File: rtl/event_counter_bank.sv
module event_counter_bank
  import pmu_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  logic [NUM_EVT-1:0]  events,
  input  logic                supervisor,
  input  logic                mark,
  output logic                irq
);

  ctrStrobe_t                    strobe;
  logic [NUM_CTR-1:0][CNT_W-1:0] cntVal;

  pmu_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .events     (events),
    .supervisor (supervisor),
    .mark       (mark),
    .cntVal     (cntVal),
    .strobe     (strobe),
    .regRdData  (regRdData),
    .irq        (irq)
  );

  pmu_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .cntVal (cntVal)
  );

endmodule

// File: tb/sim_event_counter_bank.sv
`timescale 1ns/1ps
module sim_event_counter_bank;
  localparam real HALF = 2.5;  // 200 MHz

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [15:0] events = '0;
  logic        supervisor = 1'b0;
  logic        mark = 1'b0;
  logic        irq;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  localparam logic [3:0] GLB = 4'h0;

  always #(HALF) clk = ~clk;

  event_counter_bank u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .events(events),
    .supervisor(supervisor), .mark(mark), .irq(irq)
  );

  function automatic logic [3:0] cntA(int i); return 4'(4 + i); endfunction
  function automatic logic [3:0] lclA(int i); return 4'(8 + i); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #0.1;
    d = regRdData;
  endtask

  task automatic pulse(logic [15:0] e, int n);
    events = e;
    repeat (n) @(negedge clk);
    events = '0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(GLB, v); chk("R1 global", v, 32'h1);
    for (int i = 0; i < 4; i++) begin
      rd(cntA(i), v); chk("R1 count", v, 32'h0);
      rd(lclA(i), v); chk("R1 local", v, 32'h3E00);
    end
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R7 reset freeze-all holds a counter with no local freeze
    wr(lclA(0), 32'h0);
    pulse(16'h0001, 3);
    rd(cntA(0), v); chk("R7 frozen by reset freeze-all", v, 32'h0);

    // R2 register layout
    wr(lclA(2), 32'hFFFF_FFFF);
    rd(lclA(2), v); chk("R2 local readback", v, 32'h0000_3F0F);
    wr(lclA(2), 32'h3E00);
    for (int a = 12; a < 16; a++) begin
      rd(4'(a), v); chk("R2 group3 reads zero", v, 32'h0);
    end
    wr(GLB, 32'hFFFF_FFF8);
    rd(GLB, v); chk("R2 global unused bits", v, 32'h0);

    // R3 select sweep over every counter and every event line
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < 16; s++) begin
        int k;
        k = 1 + (c + s) % 4;
        wr(lclA(c), 32'(s));
        wr(cntA(c), 32'h0);
        pulse(16'hFFFF ^ (16'h1 << s), 2);
        pulse(16'h1 << s, k);
        rd(cntA(c), v); chk("R3 selected event count", v, 32'(k));
      end
    end

    // R4 R5 R6 freeze sweep on counter 0
    for (int f = 0; f < 32; f++) begin
      for (int sm = 0; sm < 4; sm++) begin
        bit s, m, frz;
        s = sm[0]; m = sm[1];
        frz = f[0] | (f[1] & s) | (f[2] & !s) | (f[3] & !m) | (f[4] & m);
        wr(lclA(0), 32'(f) << 9);
        wr(cntA(0), 32'h0);
        supervisor = s; mark = m;
        pulse(16'h0001, 3);
        rd(cntA(0), v);
        chk(f[0] ? "R4 freeze-always" : ((f[1] | f[2]) ? "R5 privilege freeze" : "R6 mark freeze"),
            v, frz ? 32'h0 : 32'h3);
      end
    end
    supervisor = 1'b0; mark = 1'b0;

    // R7 global freeze-all
    wr(GLB, 32'h1);
    wr(lclA(0), 32'h0);
    wr(cntA(0), 32'h0);
    pulse(16'h0001, 3);
    rd(cntA(0), v); chk("R7 global freeze", v, 32'h0);
    wr(GLB, 32'h0);

    // R8 write beats increment
    @(negedge clk);
    events = 16'h0001; regWrEn = 1'b1; regAddr = cntA(0); regWrData = 32'h100;
    @(negedge clk);
    regWrEn = 1'b0; events = '0;
    rd(cntA(0), v); chk("R8 write wins", v, 32'h100);

    // R11 wrap
    wr(cntA(0), 32'hFFFF_FFFF);
    pulse(16'h0001, 1);
    rd(cntA(0), v); chk("R11 wrap", v, 32'h0);

    // R9 interrupt
    for (int i = 1; i < 4; i++) wr(lclA(i), 32'h3E00);
    wr(GLB, 32'h2);
    wr(lclA(0), 32'h100);
    wr(cntA(0), 32'h7FFF_FFFE);
    chk("R9 irq low before", {31'b0, irq}, 32'h0);
    pulse(16'h0001, 1);
    chk("R9 irq low at 7FFFFFFF", {31'b0, irq}, 32'h0);
    pulse(16'h0001, 1);
    chk("R9 irq high at bit31", {31'b0, irq}, 32'h1);
    repeat (3) @(negedge clk);
    chk("R9 irq stays", {31'b0, irq}, 32'h1);
    wr(GLB, 32'h0);
    chk("R9 irq gated by enable", {31'b0, irq}, 32'h0);
    wr(GLB, 32'h2);
    chk("R9 irq enable again", {31'b0, irq}, 32'h1);
    wr(lclA(0), 32'h0);
    chk("R9 irq gated by cond enable", {31'b0, irq}, 32'h0);
    wr(lclA(0), 32'h100);
    chk("R9 irq cond enable again", {31'b0, irq}, 32'h1);
    wr(cntA(0), 32'h0);
    chk("R9 irq cleared by rewrite", {31'b0, irq}, 32'h0);

    // R10 freeze on condition
    wr(GLB, 32'h0);
    wr(lclA(1), 32'h0);
    wr(cntA(1), 32'h0);
    wr(cntA(0), 32'h7FFF_FFFE);
    wr(GLB, 32'h4);
    pulse(16'h0001, 6);
    rd(cntA(0), v); chk("R10 counter stops one past", v, 32'h8000_0001);
    rd(cntA(1), v); chk("R10 other counter frozen", v, 32'h3);
    rd(GLB, v); chk("R10 freeze-all set", v, 32'h5);
    wr(GLB, 32'h4);
    rd(GLB, v); chk("R10 hardware set overrides clear", v, 32'h5);
    wr(cntA(0), 32'h0);
    wr(GLB, 32'h4);
    rd(GLB, v); chk("R10 released after rewrite", v, 32'h4);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule